// File: doc/BRIEF.md
# Oscillator Warm-Up Match Timer

This block counts a settling delay for an oscillator that has just been switched on, so that the system clock moves to it only once it is stable. Two 8-bit counter stages are chained into one 16-bit up-counter. The counter advances on source-clock enable ticks while the run bit is set. Only the upper byte of the programmed compare value is used. A programmed upper byte of N gives a wait of N x 256 ticks, and a value of zero stands for 256.

When the wait ends, the block raises a one-cycle interrupt pulse, clears the counter and sets a sticky pending flag. Software clears that flag with a write-one acknowledge. A small clock-select controller sits alongside the timer. Software first turns on the low-frequency oscillator. An acknowledge of a pending warm-up interrupt then moves the system clock selection onto the low-frequency source. After that, the high-frequency oscillator may be switched off, and a request to switch it off while it is still selected is refused.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, irq and irq_pending are 0, warm_count is 0, hf_osc_on is 1, lf_osc_on is 0 and sys_sel_lf is 0 (0 = high-frequency clock selected).
- R2: With start held at 1, warm_count increments once per cycle in which src_tick is 1, beginning with the cycle after the first cycle in which start is sampled as 1. irq is high in the cycle that follows the clock edge counting tick number hi x 256, where hi is the upper byte of the compare register.
- R3: The lower byte of the compare register has no effect on the wait length.
- R4: An upper compare byte of 0x00 gives a wait of 65536 ticks.
- R5: irq is high for exactly one cycle per match. The counter is 0 in that cycle and keeps counting toward the next match while start stays at 1.
- R6: irq_pending becomes 1 together with irq. It stays at 1 until a cycle with irq_ack at 1 clears it, and a new match in the same cycle takes priority over the acknowledge.
- R7: A cycle with start at 0 clears warm_count to 0. A later start counts again from zero.
- R8: A compare write made while counting does not change the running wait. It takes effect from the next start.
- R9: sys_sel_lf changes to 1 only in response to irq_ack while irq_pending is 1 and lf_osc_on is 1. lf_osc_on changes to 1 on lf_en_req.
- R10: hf_off_req clears hf_osc_on only when sys_sel_lf is already 1. Otherwise it is ignored.
- R11: Cycles with src_tick at 0 do not advance warm_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare value to write |
| start | input | 1 | Run bit: 1 counts, 0 stops and clears |
| src_tick | input | 1 | Source-clock enable, one tick per high cycle |
| irq_ack | input | 1 | Write-one clear of the pending flag |
| lf_en_req | input | 1 | Turn on the low-frequency oscillator |
| hf_off_req | input | 1 | Turn off the high-frequency oscillator |
| irq | output | 1 | One-cycle warm-up done pulse |
| irq_pending | output | 1 | Sticky warm-up done flag |
| warm_count | output | 16 | Current counter value |
| lf_osc_on | output | 1 | Low-frequency oscillator enable |
| hf_osc_on | output | 1 | High-frequency oscillator enable |
| sys_sel_lf | output | 1 | System clock select, 1 = low-frequency |

## Verification
The single-cycle interrupt property assumes that consecutive matches are at least two cycles apart. This holds because every wait is a multiple of 256 ticks. The controller properties assume that software acknowledges only after enabling the slow oscillator if it wants the switch to happen. The stimulus deliberately also acknowledges before that point, to show the refusal. All inputs change half a period away from the sampling edge, and every check is made against a behavioural model of the requirements.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef struct packed {
    logic lf_on;
    logic hf_on;
    logic sel_lf;
  } clk_state_t;

  localparam clk_state_t CLK_RESET = '{lf_on: 1'b0, hf_on: 1'b1, sel_lf: 1'b0};
endpackage

// File: rtl/wu_stage.sv
module wu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] val,
  output logic         all_ones
);
  logic [W-1:0] q, q_nx;

  always_comb begin
    q_nx = q;
    if (clr)      q_nx = '0;
    else if (inc) q_nx = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  assign val      = q;
  assign all_ones = &q;
endmodule

// File: rtl/wu_counter.sv
module wu_counter #(
  parameter int SW = 8,
  parameter int NS = 2,
  localparam int CW = SW * NS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          stop,
  input  logic [SW-1:0] tgt_m1,
  output logic [CW-1:0] count,
  output logic          match
);
  logic [NS-1:0] inc_v;
  logic [NS-1:0] ones_v;
  logic          clr_all;

  assign clr_all = stop | match;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign inc_v[g] = step;
      end else begin : g_next
        assign inc_v[g] = inc_v[g-1] & ones_v[g-1];
      end
      wu_stage #(.W(SW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc_v[g]),
        .clr      (clr_all),
        .val      (count[g*SW +: SW]),
        .all_ones (ones_v[g])
      );
    end
  endgenerate

  // Top stage is about to roll past tgt-1 with every lower stage full.
  assign match = inc_v[NS-1] & (count[CW-1 -: SW] == tgt_m1);
endmodule

// File: rtl/wu_clk_sel.sv
module wu_clk_sel
  import wu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lf_en_req,
  input  logic ack_done,
  input  logic hf_off_req,
  output clk_state_t st
);
  clk_state_t st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    if (lf_en_req) st_nx.lf_on = 1'b1;
    if (ack_done && st_q.lf_on) st_nx.sel_lf = 1'b1;
    if (hf_off_req && st_q.sel_lf) st_nx.hf_on = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CLK_RESET;
    else        st_q <= st_nx;
  end

  assign st = st_q;
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import wu_pkg::*;
#(
  parameter int STAGE_W  = 8,
  parameter int N_STAGES = 2,
  localparam int CW = STAGE_W * N_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          start,
  input  logic          src_tick,
  input  logic          irq_ack,
  input  logic          lf_en_req,
  input  logic          hf_off_req,
  output logic          irq,
  output logic          irq_pending,
  output logic [CW-1:0] warm_count,
  output logic          lf_osc_on,
  output logic          hf_osc_on,
  output logic          sys_sel_lf
);
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [CW-1:0]      cmp_q, cmp_nx;
  logic [STAGE_W-1:0] tgt_q, tgt_nx;
  logic               run_q;
  logic               irq_q, pend_q, pend_nx;
  logic               match;
  logic               step;
  clk_state_t         cs;

  assign step = start & run_q & src_tick;

  always_comb begin
    cmp_nx = cmp_q;
    if (cmp_wr) cmp_nx = cmp_wdata;
    tgt_nx = tgt_q;
    if (!run_q) tgt_nx = cmp_q[CW-1 -: STAGE_W];
    pend_nx = pend_q;
    if (match)        pend_nx = 1'b1;
    else if (irq_ack) pend_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_q  <= '0;
      tgt_q  <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_nx;
      tgt_q  <= tgt_nx;
      run_q  <= start;
      irq_q  <= match;
      pend_q <= pend_nx;
    end
  end

  wu_counter #(.SW(STAGE_W), .NS(N_STAGES)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (step),
    .stop   (~start),
    .tgt_m1 (tgt_q - 1'b1),
    .count  (warm_count),
    .match  (match)
  );

  wu_clk_sel u_csel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lf_en_req  (lf_en_req),
    .ack_done   (irq_ack & pend_q),
    .hf_off_req (hf_off_req),
    .st         (cs)
  );

  assign irq         = irq_q;
  assign irq_pending = pend_q;
  assign lf_osc_on   = cs.lf_on;
  assign hf_osc_on   = cs.hf_on;
  assign sys_sel_lf  = cs.sel_lf;
endmodule

// File: rtl/wu_checker.sv
module wu_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          irq_ack,
  input logic          irq,
  input logic          pend,
  input logic [CW-1:0] cnt,
  input logic          lf_on,
  input logic          hf_on,
  input logic          sel_lf
);
  AST_IRQ_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R5
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) irq |-> cnt == '0); // R5
  AST_IRQ_PENDS:    assert property (@(posedge clk) disable iff (!rst_n) irq |-> pend); // R6
  AST_PEND_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) (pend && !irq_ack) |=> pend); // R6
  AST_STOP_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) !start |=> cnt == '0); // R7
  AST_SEL_NEEDS_LF: assert property (@(posedge clk) disable iff (!rst_n) sel_lf |-> lf_on); // R9
  AST_HF_OFF_SAFE:  assert property (@(posedge clk) disable iff (!rst_n) !hf_on |-> sel_lf); // R10
endmodule

bind osc_warmup_timer wu_checker #(.CW(CW)) u_wu_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .irq_ack (irq_ack),
  .irq     (irq),
  .pend    (irq_pending),
  .cnt     (warm_count),
  .lf_on   (lf_osc_on),
  .hf_on   (hf_osc_on),
  .sel_lf  (sys_sel_lf)
);

// File: tb/osc_warmup_timer_bench.sv
module osc_warmup_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        start = 1'b0;
  logic        src_tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic        lf_en_req = 1'b0;
  logic        hf_off_req = 1'b0;
  logic        irq, irq_pending, lf_osc_on, hf_osc_on, sys_sel_lf;
  logic [15:0] warm_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chk_en = 0;
  bit done = 0;

  always #4 clk = ~clk;

  osc_warmup_timer u_osc_warmup_timer (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .start(start), .src_tick(src_tick), .irq_ack(irq_ack),
    .lf_en_req(lf_en_req), .hf_off_req(hf_off_req), .irq(irq),
    .irq_pending(irq_pending), .warm_count(warm_count),
    .lf_osc_on(lf_osc_on), .hf_osc_on(hf_osc_on), .sys_sel_lf(sys_sel_lf)
  );

  // Behavioural reference model
  int m_rc, m_cmp, m_tgt, m_cnt;
  bit m_run, m_irq, m_pend, m_lf, m_hf, m_sel;

  always @(posedge clk) begin
    int wait_len;
    bit hit;
    int n_cmp, n_tgt, n_cnt;
    bit n_pend, n_lf, n_hf, n_sel;
    if (!rst_n || m_rc < 2) begin
      m_rc = rst_n ? m_rc + 1 : 0;
      m_cmp = 0; m_tgt = 0; m_cnt = 0; m_run = 0; m_irq = 0; m_pend = 0;
      m_lf = 0; m_hf = 1; m_sel = 0;
    end else begin
      wait_len = (m_tgt == 0 ? 256 : m_tgt) * 256;
      hit = start && m_run && src_tick && (m_cnt == wait_len - 1);
      n_cmp = cmp_wr ? int'(cmp_wdata) : m_cmp;
      n_tgt = m_run ? m_tgt : (m_cmp >> 8);
      if (!start || hit)             n_cnt = 0;
      else if (m_run && src_tick)    n_cnt = m_cnt + 1;
      else                           n_cnt = m_cnt;
      n_pend = hit ? 1'b1 : (irq_ack ? 1'b0 : m_pend);
      n_lf  = m_lf | lf_en_req;
      n_sel = m_sel | (irq_ack && m_pend && m_lf);
      n_hf  = m_hf & !(hf_off_req && m_sel);
      m_cmp = n_cmp; m_tgt = n_tgt; m_cnt = n_cnt; m_run = start;
      m_irq = hit; m_pend = n_pend; m_lf = n_lf; m_sel = n_sel; m_hf = n_hf;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (chk_en && !done) begin
      chk("R5 irq", int'(irq), int'(m_irq));
      chk("R6 irq_pending", int'(irq_pending), int'(m_pend));
      chk("R2 warm_count", int'(warm_count), m_cnt);
      chk("R9 lf_osc_on", int'(lf_osc_on), int'(m_lf));
      chk("R9 sys_sel_lf", int'(sys_sel_lf), int'(m_sel));
      chk("R10 hf_osc_on", int'(hf_osc_on), int'(m_hf));
    end
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    cmp_wr = 1'b1; cmp_wdata = v; cyc(1); cmp_wr = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  // Cycles from the start-setting negedge until irq is seen
  task automatic run_wait(output int n);
    n = 0;
    start = 1'b1;
    do begin cyc(1); n++; end while (!irq && n < 70000);
  endtask

  initial begin
    int n;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk_en = 1;
    cyc(3);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pending", int'(irq_pending), 0);
    chk("R1 count", int'(warm_count), 0);
    chk("R1 hf_on", int'(hf_osc_on), 1);
    chk("R1 lf_on", int'(lf_osc_on), 0);
    chk("R1 sel", int'(sys_sel_lf), 0);

    src_tick = 1'b1;
    wr_cmp(16'h0100);
    run_wait(n);
    chk("R2 wait 0x0100", n, 257);
    cyc(1);
    chk("R5 irq one cycle", int'(irq), 0);
    chk("R6 pending sticky", int'(irq_pending), 1);

    // Ack before low-frequency oscillator is on: no switch (R9)
    pulse(irq_ack);
    chk("R6 ack clears", int'(irq_pending), 0);
    chk("R9 no switch without lf", int'(sys_sel_lf), 0);
    pulse(hf_off_req);
    chk("R10 hf off refused", int'(hf_osc_on), 1);

    // R8: write while running, current wait unchanged
    wr_cmp(16'h0300);
    n = 0;
    do begin cyc(1); n++; end while (!irq && n < 70000);
    chk("R8 running wait unchanged", int'(irq), 1);
    start = 1'b0; cyc(2);
    chk("R7 stop clears", int'(warm_count), 0);
    run_wait(n);
    chk("R8 new value at next start", n, 3 * 256 + 1);
    start = 1'b0; cyc(1);

    // R3: low byte ignored
    wr_cmp(16'h01FF);
    cyc(1);
    run_wait(n);
    chk("R3 low byte ignored", n, 257);
    start = 1'b0; cyc(1);

    // R11: no ticks, no count
    src_tick = 1'b0;
    start = 1'b1; cyc(20);
    chk("R11 no tick no count", int'(warm_count), 0);
    for (int k = 0; k < 900; k++) begin
      src_tick = (k % 3 == 0);
      cyc(1);
    end
    src_tick = 1'b1;
    start = 1'b0; cyc(2);

    // R9/R10: enable lf, ack a pending irq, switch, then hf off
    pulse(lf_en_req);
    chk("R9 lf on", int'(lf_osc_on), 1);
    pulse(hf_off_req);
    chk("R10 hf off refused while selected", int'(hf_osc_on), 1);
    chk("R9 pending before ack", int'(irq_pending), 1);
    pulse(irq_ack);
    chk("R9 switched to lf", int'(sys_sel_lf), 1);
    pulse(hf_off_req);
    chk("R10 hf off accepted", int'(hf_osc_on), 0);

    // R4: zero upper byte means full range
    wr_cmp(16'h0000);
    cyc(1);
    run_wait(n);
    chk("R4 full-range wait", n, 65537);
    start = 1'b0; cyc(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule